// File: doc/BRIEF.md
# Banked Memory Arbiter with Atomic Sequence Lock

This block is the front end of a small on-chip memory shared by several requesting ports. Each port offers one request at a time on a valid/ready channel: a word address, write data, a write enable and an atomicity flag. The memory is split into banks chosen by the upper address bits. Each bank picks one request per cycle. While a bank is unlocked it grants ports in round-robin order. It returns the word's content on the issuing port one cycle after acceptance.

The atomicity flag lets a port run a multi-step read-modify-write, such as a test-and-set on a lock word, with no interleaving from other ports. When a bank accepts a request with the flag set, it binds itself to that port. Other ports then wait with ready low, and their requests stay intact. The bank frees itself after it serves the owner's next request that has the flag clear. A sequence of N operations therefore sends N-1 requests with the flag set and a last one with it clear. Every bank keeps its own owner, so a lock held in one bank never stalls traffic to another bank.

Top module: `atomic_mem_arbiter`

## Requirements
- R1: After reset no response is valid, every bank is unlocked, and each bank's round-robin pointer starts at port 0, so port 0 wins first when all ports request together.
- R2: In an unlocked bank with several ports requesting, grants rotate in increasing port order, starting after the last port served and wrapping from the highest port to port 0.
- R3: A bank accepts at most one request per cycle, and ready is raised only for a port that is asserting valid.
- R4: A response is valid on the issuing port, and on no other, exactly one cycle after acceptance. Its data is the word's content before that request's own write.
- R5: An accepted request with write enable 1 stores its write data in the addressed word, and a later read returns that value.
- R6: Once a bank accepts a request with the atomic flag at 1, only that owner port can be granted by that bank. Other ports targeting the bank see ready 0.
- R7: The owner's request with the atomic flag at 0 is served, and the bank is unlocked from the next cycle, when another waiting port can be granted.
- R8: A request with the atomic flag at 0 accepted by an unlocked bank leaves it unlocked.
- R9: A request held back by a lock is neither dropped nor altered. It is served after the lock is released and sees the owner's writes.
- R10: The bank index is the top address bits above the word bits (bit 4 with defaults). A lock in one bank has no effect on requests to another bank.
- R11: With the flag word holding 0 for free and 1 for taken, two ports racing a test-and-set (atomic read, then a closing write of 1) never both read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | NUM_PORTS | Per-port request offered |
| req_ready | output | NUM_PORTS | Per-port request accepted this cycle |
| req_addr | input | NUM_PORTS*ADDR_W | Per-port address: bank bits over word bits |
| req_wdata | input | NUM_PORTS*DATA_W | Per-port write data |
| req_we | input | NUM_PORTS | Per-port write enable |
| req_atomic | input | NUM_PORTS | Per-port atomicity flag (1 keeps the bank locked) |
| rsp_valid | output | NUM_PORTS | Per-port response valid |
| rsp_rdata | output | NUM_PORTS*DATA_W | Per-port read data (word value before the write) |

## Verification
Ready depends combinationally on valid and the bank state, so the bench samples it just after it drives inputs on the falling edge, in the same cycle. The response and any lock change are due one rising edge after acceptance, so the bench checks them on the next falling edge. Write data becomes visible to a read accepted on any later cycle. Held ports are checked cycle by cycle for ready low until the owner's closing request is accepted. One cycle after that, the held port must see ready high.

// File: rtl/amx_pkg.sv
// Package: shared state type and index helpers for the banked atomic arbiter.
// Assumes: integer arithmetic on small port counts only.
package amx_pkg;

    typedef enum logic {
        LK_OPEN = 1'b0,
        LK_HELD = 1'b1
    } lock_state_e;

    // Next port index in circular order.
    function automatic int wrap_next(input int idx, input int n);
        return (idx + 1 >= n) ? 0 : idx + 1;
    endfunction

    // Bit width able to index v items, never below 1.
    function automatic int clog2_min1(input int v);
        return (v > 1) ? $clog2(v) : 1;
    endfunction

endpackage

// File: rtl/amx_lock_rr.sv
// Module: per-bank grant logic. Grants one requesting port per cycle,
// round-robin while open. It binds to a port after that port's request with
// the atomic flag set, and it frees the bank after the owner's request with
// the flag clear. Assumes grant is taken as acceptance (ready) in this cycle.
module amx_lock_rr
    import amx_pkg::*;
#(
    parameter int NUM_PORTS = 3,
    localparam int PW = clog2_min1(NUM_PORTS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_PORTS-1:0] req_vld,
    input  logic [NUM_PORTS-1:0] req_atm,
    output logic [NUM_PORTS-1:0] grant,
    output logic                 grant_any,
    output logic [PW-1:0]        grant_idx
);

    lock_state_e   lock_q;
    logic [PW-1:0] owner_q;
    logic [PW-1:0] ptr_q;

    // Pick the winner: the owner alone when held, else the first valid from ptr.
    always_comb begin
        int cand;
        cand      = 0;
        grant     = '0;
        grant_any = 1'b0;
        grant_idx = '0;
        if (lock_q == LK_HELD) begin
            if (req_vld[owner_q]) begin
                grant[owner_q] = 1'b1;
                grant_any      = 1'b1;
                grant_idx      = owner_q;
            end
        end else begin
            for (int k = 0; k < NUM_PORTS; k++) begin
                cand = int'(ptr_q) + k;
                if (cand >= NUM_PORTS) cand = cand - NUM_PORTS;
                if (!grant_any && req_vld[cand]) begin
                    grant[cand] = 1'b1;
                    grant_any   = 1'b1;
                    grant_idx   = PW'(cand);
                end
            end
        end
    end

    // Advance the pointer and update lock ownership on every acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock_q  <= LK_OPEN;
            owner_q <= '0;
            ptr_q   <= '0;
        end else if (grant_any) begin
            ptr_q <= PW'(wrap_next(int'(grant_idx), NUM_PORTS));
            if (req_atm[grant_idx]) begin
                lock_q  <= LK_HELD;
                owner_q <= grant_idx;
            end else begin
                lock_q  <= LK_OPEN;
            end
        end
    end

    // R3: one grant at most, and only to a requesting port.
    assert_single_grant_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant) && ((grant & ~req_vld) == '0));

    // R6: after an atomic acceptance, no other port may be granted next cycle.
    assert_lock_excludes_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_any && req_atm[grant_idx]) |=> ((grant & ~$past(grant)) == '0));

    // R7 (and R8): an accepted request with the flag clear leaves the bank open.
    assert_clear_flag_unlocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_any && !req_atm[grant_idx]) |=> (lock_q == LK_OPEN));

endmodule

// File: rtl/amx_bank.sv
// Module: one memory bank. Holds 2**WORD_BITS words and arbitrates the ports
// through amx_lock_rr. The selected request is applied in one edge: its write
// lands in the array, and the old word is registered as the response.
// Assumes: a port targets this bank only when its bk_vld bit is set.
module amx_bank
    import amx_pkg::*;
#(
    parameter int NUM_PORTS = 3,
    parameter int WORD_BITS = 4,
    parameter int DATA_W    = 8,
    localparam int DEPTH    = 1 << WORD_BITS,
    localparam int PW       = clog2_min1(NUM_PORTS)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NUM_PORTS-1:0]           bk_vld,
    input  logic [NUM_PORTS-1:0]           bk_atm,
    input  logic [NUM_PORTS-1:0]           bk_we,
    input  logic [NUM_PORTS*WORD_BITS-1:0] bk_addr,
    input  logic [NUM_PORTS*DATA_W-1:0]    bk_wdata,
    output logic [NUM_PORTS-1:0]           bk_ready,
    output logic [NUM_PORTS-1:0]           bk_rsp_vld,
    output logic [DATA_W-1:0]              bk_rdata
);

    logic [NUM_PORTS-1:0] grant;
    logic                 grant_any;
    logic [PW-1:0]        grant_idx;
    logic [WORD_BITS-1:0] sel_addr;
    logic [DATA_W-1:0]    sel_wdata;
    logic                 sel_we;
    logic [DATA_W-1:0]    words [DEPTH];
    logic [NUM_PORTS-1:0] rsp_vld_q;
    logic [DATA_W-1:0]    rdata_q;

    amx_lock_rr #(.NUM_PORTS(NUM_PORTS)) u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_vld   (bk_vld),
        .req_atm   (bk_atm),
        .grant     (grant),
        .grant_any (grant_any),
        .grant_idx (grant_idx)
    );

    // Route the winning port's fields to the array.
    always_comb begin
        sel_addr  = bk_addr[int'(grant_idx)*WORD_BITS +: WORD_BITS];
        sel_wdata = bk_wdata[int'(grant_idx)*DATA_W +: DATA_W];
        sel_we    = bk_we[grant_idx];
    end

    // Storage write for an accepted write request.
    always_ff @(posedge clk) begin
        if (grant_any && sel_we) begin
            words[sel_addr] <= sel_wdata;
        end
    end

    // Register the pre-write word and the response target port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_vld_q <= '0;
            rdata_q   <= '0;
        end else begin
            rsp_vld_q <= grant;
            if (grant_any) begin
                rdata_q <= words[sel_addr];
            end
        end
    end

    assign bk_ready   = grant;
    assign bk_rsp_vld = rsp_vld_q;
    assign bk_rdata   = rdata_q;

    // R4: an acceptance yields exactly one response next cycle.
    assert_rsp_next_cycle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        grant_any |=> $onehot(bk_rsp_vld));

    // R4: no acceptance, no response next cycle.
    assert_no_spurious_rsp_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !grant_any |=> (bk_rsp_vld == '0));

endmodule

// File: rtl/atomic_mem_arbiter.sv
// Module: top. Splits each port's address into bank and word bits, steers the
// valid to the addressed bank, and merges the banks' ready and response
// signals back per port. Assumes each port has at most one request in
// flight per cycle, so at most one bank answers a port at a time.
module atomic_mem_arbiter
    import amx_pkg::*;
#(
    parameter int NUM_PORTS = 3,
    parameter int NUM_BANKS = 2,
    parameter int WORD_BITS = 4,
    parameter int DATA_W    = 8,
    localparam int BSW      = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 0,
    localparam int BIW      = clog2_min1(NUM_BANKS),
    localparam int ADDR_W   = WORD_BITS + BSW
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_PORTS-1:0]        req_valid,
    output logic [NUM_PORTS-1:0]        req_ready,
    input  logic [NUM_PORTS*ADDR_W-1:0] req_addr,
    input  logic [NUM_PORTS*DATA_W-1:0] req_wdata,
    input  logic [NUM_PORTS-1:0]        req_we,
    input  logic [NUM_PORTS-1:0]        req_atomic,
    output logic [NUM_PORTS-1:0]        rsp_valid,
    output logic [NUM_PORTS*DATA_W-1:0] rsp_rdata
);

    logic [BIW-1:0]                 bank_of   [NUM_PORTS];
    logic [NUM_PORTS*WORD_BITS-1:0] word_addr;
    logic [NUM_PORTS-1:0]           bk_vld    [NUM_BANKS];
    logic [NUM_PORTS-1:0]           bk_ready  [NUM_BANKS];
    logic [NUM_PORTS-1:0]           bk_rsp    [NUM_BANKS];
    logic [DATA_W-1:0]              bk_rdata  [NUM_BANKS];

    // Split every port address into its bank index and word offset.
    generate
        if (BSW > 0) begin : g_bank_sel
            always_comb begin
                for (int p = 0; p < NUM_PORTS; p++) begin
                    bank_of[p] = BIW'(req_addr[p*ADDR_W + WORD_BITS +: BSW]);
                end
            end
        end else begin : g_one_bank
            always_comb begin
                for (int p = 0; p < NUM_PORTS; p++) begin
                    bank_of[p] = '0;
                end
            end
        end
    endgenerate

    // Gather word offsets of all ports into one vector for the banks.
    always_comb begin
        for (int p = 0; p < NUM_PORTS; p++) begin
            word_addr[p*WORD_BITS +: WORD_BITS] = req_addr[p*ADDR_W +: WORD_BITS];
        end
    end

    // One bank instance per address slice, each with its own lock.
    generate
        for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
            // Steer each port's valid to this bank when the address selects it.
            always_comb begin
                for (int p = 0; p < NUM_PORTS; p++) begin
                    bk_vld[b][p] = req_valid[p] && (bank_of[p] == BIW'(b));
                end
            end

            amx_bank #(
                .NUM_PORTS (NUM_PORTS),
                .WORD_BITS (WORD_BITS),
                .DATA_W    (DATA_W)
            ) u_bank (
                .clk        (clk),
                .rst_n      (rst_n),
                .bk_vld     (bk_vld[b]),
                .bk_atm     (req_atomic),
                .bk_we      (req_we),
                .bk_addr    (word_addr),
                .bk_wdata   (req_wdata),
                .bk_ready   (bk_ready[b]),
                .bk_rsp_vld (bk_rsp[b]),
                .bk_rdata   (bk_rdata[b])
            );
        end
    endgenerate

    // Merge ready and response from the banks back onto each port.
    always_comb begin
        req_ready = '0;
        rsp_valid = '0;
        rsp_rdata = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            req_ready = req_ready | bk_ready[b];
            rsp_valid = rsp_valid | bk_rsp[b];
            for (int p = 0; p < NUM_PORTS; p++) begin
                if (bk_rsp[b][p]) begin
                    rsp_rdata[p*DATA_W +: DATA_W] = rsp_rdata[p*DATA_W +: DATA_W] | bk_rdata[b];
                end
            end
        end
    end

    // R4: every accepted port is answered on the following cycle.
    assert_accept_answered_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (|(req_valid & req_ready)) |=> ((rsp_valid & $past(req_valid & req_ready)) == $past(req_valid & req_ready)));

    // R3: ready never reaches a port that is not requesting.
    assert_ready_needs_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready & ~req_valid) == '0);

endmodule

// File: tb/test_atomic_mem_arbiter.sv
// Directed bench: one task per scenario, each checking its own results.
module test_atomic_mem_arbiter;

    localparam int CLK_PERIOD = 10;
    localparam int NP  = 3;
    localparam int DW  = 8;
    localparam int AW  = 5;
    localparam int BK1 = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;

    logic          b_vld   [NP];
    logic          b_we    [NP];
    logic          b_atm   [NP];
    logic [AW-1:0] b_addr  [NP];
    logic [DW-1:0] b_wdata [NP];

    logic [NP-1:0]    req_valid, req_ready, req_we, req_atomic, rsp_valid;
    logic [NP*AW-1:0] req_addr;
    logic [NP*DW-1:0] req_wdata, rsp_rdata;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    always_comb begin
        for (int p = 0; p < NP; p++) begin
            req_valid[p]             = b_vld[p];
            req_we[p]                = b_we[p];
            req_atomic[p]            = b_atm[p];
            req_addr[p*AW +: AW]     = b_addr[p];
            req_wdata[p*DW +: DW]    = b_wdata[p];
        end
    end

    atomic_mem_arbiter i_atomic_mem_arbiter (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .req_we     (req_we),
        .req_atomic (req_atomic),
        .rsp_valid  (rsp_valid),
        .rsp_rdata  (rsp_rdata)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic drive(input int p, input bit v, input int a, input int d, input bit we, input bit atm);
        b_vld[p]   = v;
        b_addr[p]  = AW'(a);
        b_wdata[p] = DW'(d);
        b_we[p]    = we;
        b_atm[p]   = atm;
    endtask

    // Issue one request from port p at a falling edge; wait for ready; return response data.
    task automatic do_req(input int p, input int a, input int d, input bit we, input bit atm,
                          output logic [DW-1:0] rd);
        drive(p, 1'b1, a, d, we, atm);
        while (1) begin
            #1;
            if (req_ready[p]) break;
            @(negedge clk);
        end
        @(posedge clk);
        @(negedge clk);
        check(rsp_valid[p], "R4 response valid on issuer", int'(rsp_valid), 1 << p);
        rd = rsp_rdata[p*DW +: DW];
        b_vld[p] = 1'b0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        #1;
        check(rsp_valid == '0, "R1 no response after reset", int'(rsp_valid), 0);
        check(req_ready == '0, "R1 no ready without valid", int'(req_ready), 0);
    endtask

    task automatic t_rotation();
        logic [NP-1:0] seen;
        for (int p = 0; p < NP; p++) drive(p, 1'b1, 0, 0, 1'b0, 1'b0);
        for (int c = 0; c < 6; c++) begin
            #1;
            seen = req_ready;
            check(seen == NP'(1 << (c % NP)), (c == 0) ? "R1 port 0 first" : "R2 rotation",
                  int'(seen), 1 << (c % NP));
            @(posedge clk);
            @(negedge clk);
            check(rsp_valid == seen, "R4 response on issuing port only", int'(rsp_valid), int'(seen));
        end
        for (int p = 0; p < NP; p++) b_vld[p] = 1'b0;
    endtask

    task automatic t_write_read();
        logic [DW-1:0] rd;
        do_req(1, 3, 8'h5A, 1'b1, 1'b0, rd);
        do_req(2, 3, 0, 1'b0, 1'b0, rd);
        check(rd == 8'h5A, "R5 read returns written word", int'(rd), 8'h5A);
        do_req(0, 3, 8'hC3, 1'b1, 1'b0, rd);
        check(rd == 8'h5A, "R4 write returns prior word", int'(rd), 8'h5A);
        do_req(2, 3, 0, 1'b0, 1'b0, rd);
        check(rd == 8'hC3, "R5 overwrite visible", int'(rd), 8'hC3);
    endtask

    task automatic t_plain_no_lock();
        logic [DW-1:0] rd;
        do_req(0, 2, 0, 1'b0, 1'b0, rd);
        drive(1, 1'b1, 2, 0, 1'b0, 1'b0);
        #1;
        check(req_ready[1], "R8 plain request leaves bank open", int'(req_ready), 2);
        @(posedge clk);
        @(negedge clk);
        b_vld[1] = 1'b0;
    endtask

    task automatic t_lock_hold();
        logic [DW-1:0] rd;
        do_req(0, 5, 0, 1'b0, 1'b1, rd);
        drive(1, 1'b1, 5, 0, 1'b0, 1'b0);
        for (int c = 0; c < 3; c++) begin
            #1;
            check(req_ready[1] == 1'b0, "R6 non-owner held", int'(req_ready), 0);
            @(negedge clk);
        end
        drive(0, 1'b1, 5, 8'h77, 1'b1, 1'b0);
        #1;
        check(req_ready == 3'b001, "R6 owner served while other waits", int'(req_ready), 1);
        @(posedge clk);
        @(negedge clk);
        b_vld[0] = 1'b0;
        #1;
        check(req_ready[1], "R7 released after closing request", int'(req_ready), 2);
        @(posedge clk);
        @(negedge clk);
        check(rsp_valid[1] && rsp_rdata[DW +: DW] == 8'h77, "R9 held request served intact",
              int'(rsp_rdata[DW +: DW]), 8'h77);
        b_vld[1] = 1'b0;
    endtask

    task automatic t_bank_split();
        logic [DW-1:0] rd;
        do_req(0, BK1 + 1, 0, 1'b0, 1'b1, rd);
        drive(1, 1'b1, 2, 0, 1'b0, 1'b0);
        drive(2, 1'b1, BK1 + 1, 0, 1'b0, 1'b0);
        #1;
        check(req_ready == 3'b010, "R10 other bank unaffected by lock", int'(req_ready), 2);
        @(posedge clk);
        @(negedge clk);
        b_vld[1] = 1'b0;
        #1;
        check(req_ready == 3'b000, "R6 locked bank holds port 2", int'(req_ready), 0);
        @(negedge clk);
        do_req(0, BK1 + 1, 8'h3C, 1'b1, 1'b0, rd);
        #1;
        check(req_ready[2], "R7 port 2 granted after release", int'(req_ready), 4);
        @(posedge clk);
        @(negedge clk);
        check(rsp_rdata[2*DW +: DW] == 8'h3C, "R9 port 2 sees owner write",
              int'(rsp_rdata[2*DW +: DW]), 8'h3C);
        b_vld[2] = 1'b0;
    endtask

    task automatic tas(input int p, output logic [DW-1:0] got);
        logic [DW-1:0] dummy;
        do_req(p, BK1 + 8, 0, 1'b0, 1'b1, got);
        do_req(p, BK1 + 8, 1, 1'b1, 1'b0, dummy);
    endtask

    task automatic t_tas_race();
        logic [DW-1:0] r0, r2, rd;
        int winner, loser;
        do_req(0, BK1 + 8, 0, 1'b1, 1'b0, rd);
        fork
            tas(0, r0);
            tas(2, r2);
        join
        check(((r0 == 0) ? 1 : 0) + ((r2 == 0) ? 1 : 0) == 1, "R11 exactly one racer wins",
              int'({r0, r2}), 1);
        winner = (r0 == 0) ? 0 : 2;
        loser  = (winner == 0) ? 2 : 0;
        do_req(winner, BK1 + 8, 0, 1'b1, 1'b0, rd);
        tas(loser, rd);
        check(rd == 0, "R11 retry succeeds after release", int'(rd), 0);
    endtask

    initial begin
        for (int p = 0; p < NP; p++) drive(p, 1'b0, 0, 0, 1'b0, 1'b0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_rotation();
        t_write_read();
        t_plain_no_lock();
        t_lock_hold();
        t_bank_split();
        t_tas_race();
        repeat (2) @(negedge clk);
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule